// File: doc/BRIEF.md
# Backplane Control and Status Register Slave

This block is a register slave on a parallel backplane bus with 24-bit addresses and 16-bit data. It handles single-word reads and writes only. It answers inside a window whose top address byte matches an eight-bit switch input. Within that window it holds four kinds of register:

- a link configuration register, which drives the clock-source select and the stringent-lock enable;
- a write-only pulse register, whose bits fire one-cycle reset strobes;
- a status register, which shows live lock inputs next to sticky loss flags;
- a read port that pops words from an external FIFO.

A transfer starts when the master raises `bus_valid`. The master holds address, direction and write data until the slave raises `bus_ack`, then drops `bus_valid`. Each register sits at a word-aligned offset. Address bits 1:0 are ignored.

Top module: `csr_bus_slave`

## Requirements
- R1: The slave responds only when `bus_addr[23:16]` equals `sw_base`. A transfer with any other top byte gets no `bus_ack` and changes no register.
- R2: `bus_ack` rises on the first clock edge after a matching `bus_valid` and stays high for exactly one cycle. Read data is valid on `bus_rdata` while `bus_ack` is high.
- R3: The link configuration register sits at offset 0x0068. It resets to 0x8063, and all 16 bits are writable and readable.
- R4: Bit 15 of the link configuration register drives `clk_sel_local`: 1 selects the local oscillator, 0 selects the recovered link clock. Bit 7 drives `strict_lock`.
- R5: A write to offset 0x000C fires one-cycle strobes, high together with `bus_ack`, and several can fire in one write. Bit 2 fires `fifo_reset_p`, bit 3 fires `trig_clr_p` and bit 5 fires `lost_clr_p`. A read of offset 0x000C returns 0x0000.
- R6: The status register sits at offset 0x0008, and writes to it have no effect. Its fields are:
  - bit 0: live `link_lock_in`
  - bit 1: live `sm_lock_in`
  - bit 2: sticky link-loss flag
  - bit 3: sticky state-machine-loss flag
  - all other bits: 0
- R7: A sticky loss flag is set on every cycle in which its lock input is low. Only `lost_clr_p` clears it, on the edge after the strobe. A new loss in the same cycle as the clear keeps the flag set.
- R8: A read of offset 0x1000 returns `fifo_rdata` and pulses `fifo_rd_en` for one cycle, together with `bus_ack`. A write to that offset produces no `fifo_rd_en`.
- R9: A read of an unmapped offset inside the window is acknowledged and returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_base | input | 8 | Static switch value for address bits 23:16 |
| bus_valid | input | 1 | Transfer request, held until acknowledged |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 24 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_ack | output | 1 | One-cycle transfer acknowledge |
| bus_rdata | output | 16 | Read data, valid with `bus_ack` |
| link_lock_in | input | 1 | Physical link lock |
| sm_lock_in | input | 1 | Receive state machine lock |
| fifo_rdata | input | 16 | Head word of the external FIFO |
| fifo_rd_en | output | 1 | One-cycle FIFO pop strobe |
| clk_sel_local | output | 1 | Clock source select, 1 = local oscillator |
| strict_lock | output | 1 | Stringent lock criterion enable |
| fifo_reset_p | output | 1 | FIFO reset strobe |
| trig_clr_p | output | 1 | Trigger counter clear strobe |
| lost_clr_p | output | 1 | Sticky loss flag clear strobe |

## Verification
The bench builds the slave with its default parameters: configuration reset value 0x8063 and offsets 0x0008, 0x000C, 0x0068 and 0x1000. This makes the documented write values 0x0063, 0x00E3 and 0x002C directly usable as stimulus.

Random traffic mixes four kinds of transfer:
- configuration writes;
- configuration readbacks;
- writes carrying a foreign top address byte, which must be ignored;
- reads of unmapped offsets.

Directed sequences cover the combined strobe write, the clear-versus-new-loss collision and FIFO pops.

// File: rtl/csr_bus_slave.sv
module csr_bus_slave #(
  parameter logic [15:0] CFG_RST   = 16'h8063,
  parameter logic [15:0] OFS_STAT  = 16'h0008,
  parameter logic [15:0] OFS_PULSE = 16'h000C,
  parameter logic [15:0] OFS_CFG   = 16'h0068,
  parameter logic [15:0] OFS_FIFO  = 16'h1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  sw_base,
  input  logic        bus_valid,
  input  logic        bus_we,
  input  logic [23:0] bus_addr,
  input  logic [15:0] bus_wdata,
  output logic        bus_ack,
  output logic [15:0] bus_rdata,
  input  logic        link_lock_in,
  input  logic        sm_lock_in,
  input  logic [15:0] fifo_rdata,
  output logic        fifo_rd_en,
  output logic        clk_sel_local,
  output logic        strict_lock,
  output logic        fifo_reset_p,
  output logic        trig_clr_p,
  output logic        lost_clr_p
);

  logic [15:0] link_cfg;
  logic        lost_link, lost_sm;
  logic        hit, wr, rd;
  logic [15:0] ofs, rd_mux;

  assign hit = bus_valid && !bus_ack && (bus_addr[23:16] == sw_base);
  assign wr  = hit && bus_we;
  assign rd  = hit && !bus_we;
  assign ofs = {bus_addr[15:2], 2'b00};

  assign clk_sel_local = link_cfg[15];
  assign strict_lock   = link_cfg[7];

  always_comb begin
    rd_mux = '0;
    if (ofs == OFS_CFG)       rd_mux = link_cfg;
    else if (ofs == OFS_STAT) rd_mux = {12'd0, lost_sm, lost_link, sm_lock_in, link_lock_in};
    else if (ofs == OFS_FIFO) rd_mux = fifo_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_ack      <= 1'b0;
      bus_rdata    <= '0;
      link_cfg     <= CFG_RST;
      fifo_rd_en   <= 1'b0;
      fifo_reset_p <= 1'b0;
      trig_clr_p   <= 1'b0;
      lost_clr_p   <= 1'b0;
      lost_link    <= 1'b0;
      lost_sm      <= 1'b0;
    end else begin
      bus_ack      <= hit;
      bus_rdata    <= rd ? rd_mux : '0;
      fifo_rd_en   <= rd && (ofs == OFS_FIFO);
      fifo_reset_p <= wr && (ofs == OFS_PULSE) && bus_wdata[2];
      trig_clr_p   <= wr && (ofs == OFS_PULSE) && bus_wdata[3];
      lost_clr_p   <= wr && (ofs == OFS_PULSE) && bus_wdata[5];
      if (wr && ofs == OFS_CFG) link_cfg <= bus_wdata;
      lost_link    <= !link_lock_in || (lost_link && !lost_clr_p);
      lost_sm      <= !sm_lock_in   || (lost_sm   && !lost_clr_p);
    end
  end

endmodule

// File: rtl/csr_bus_slave_chk.sv
module csr_bus_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  sw_base,
  input logic        bus_valid,
  input logic [23:0] bus_addr,
  input logic        bus_ack,
  input logic        fifo_rd_en,
  input logic        fifo_reset_p,
  input logic        trig_clr_p,
  input logic        lost_clr_p,
  input logic        link_lock_in,
  input logic        sm_lock_in,
  input logic        clk_sel_local,
  input logic        strict_lock,
  input logic        lost_link,
  input logic        lost_sm
);

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) bus_ack |=> !bus_ack); // R2
  AST_ACK_MATCH: assert property (@(posedge clk) disable iff (!rst_n) bus_valid && !bus_ack && bus_addr[23:16] != sw_base |=> !bus_ack); // R1
  AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !bus_valid |=> $stable(clk_sel_local) && $stable(strict_lock)); // R4
  AST_STROBE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n) (fifo_reset_p || trig_clr_p || lost_clr_p) |-> bus_ack); // R5
  AST_FIFO_POP_ACK: assert property (@(posedge clk) disable iff (!rst_n) fifo_rd_en |-> bus_ack); // R8
  AST_LINK_LOSS_SET: assert property (@(posedge clk) disable iff (!rst_n) !link_lock_in |=> lost_link); // R7
  AST_SM_LOSS_SET: assert property (@(posedge clk) disable iff (!rst_n) !sm_lock_in |=> lost_sm); // R7
  AST_LOSS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) lost_link && !lost_clr_p |=> lost_link); // R7

endmodule

bind csr_bus_slave csr_bus_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sw_base(sw_base), .bus_valid(bus_valid),
  .bus_addr(bus_addr), .bus_ack(bus_ack), .fifo_rd_en(fifo_rd_en),
  .fifo_reset_p(fifo_reset_p), .trig_clr_p(trig_clr_p), .lost_clr_p(lost_clr_p),
  .link_lock_in(link_lock_in), .sm_lock_in(sm_lock_in),
  .clk_sel_local(clk_sel_local), .strict_lock(strict_lock),
  .lost_link(lost_link), .lost_sm(lost_sm)
);

// File: tb/csr_bus_slave_tb.sv
module csr_bus_slave_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sw_base = 8'h55;
  logic        bus_valid = 1'b0, bus_we = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_ack;
  logic [15:0] bus_rdata;
  logic        link_lock_in = 1'b1, sm_lock_in = 1'b1;
  logic [15:0] fifo_rdata = 16'hA5C3;
  logic        fifo_rd_en, clk_sel_local, strict_lock;
  logic        fifo_reset_p, trig_clr_p, lost_clr_p;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] m_cfg = 16'h8063;

  logic        s_ack, s_rd_en, s_fr, s_tc, s_lc;
  logic [15:0] s_rdata;

  always #2.5 clk = ~clk;

  csr_bus_slave u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] addr_of(input logic [7:0] base, input logic [15:0] ofs);
    return {base, ofs};
  endfunction

  function automatic logic [15:0] exp_status(input logic ll, input logic sl, input logic fl, input logic fs);
    return {12'd0, fs, fl, sl, ll};
  endfunction

  task automatic xfer(input logic we, input logic [23:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    s_ack = bus_ack; s_rdata = bus_rdata; s_rd_en = fifo_rd_en;
    s_fr = fifo_reset_p; s_tc = trig_clr_p; s_lc = lost_clr_p;
    @(negedge clk);
    bus_valid = 1'b0;
    @(posedge clk); #1;
    chk("R2 ack width", {31'd0, bus_ack}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R3 reset clk_sel", {31'd0, clk_sel_local}, 32'd1);
    chk("R4 reset strict", {31'd0, strict_lock}, 32'd0);
    chk("R2 reset ack", {31'd0, bus_ack}, 32'd0);

    xfer(0, addr_of(8'h55, 16'h0068), 0);
    chk("R2 ack", {31'd0, s_ack}, 32'd1);
    chk("R3 cfg reset read", {16'd0, s_rdata}, 32'h8063);

    xfer(1, addr_of(8'h55, 16'h0068), 16'h00E3); m_cfg = 16'h00E3;
    chk("R4 clk_sel link", {31'd0, clk_sel_local}, 32'd0);
    chk("R4 strict on", {31'd0, strict_lock}, 32'd1);
    xfer(1, addr_of(8'h55, 16'h006B), 16'h0063); m_cfg = 16'h0063;
    chk("R4 strict off", {31'd0, strict_lock}, 32'd0);

    xfer(1, addr_of(8'h54, 16'h0068), 16'hFFFF);
    chk("R1 foreign no ack", {31'd0, s_ack}, 32'd0);
    chk("R1 foreign ignored", {31'd0, clk_sel_local}, 32'd0);

    xfer(1, addr_of(8'h55, 16'h000C), 16'h002C);
    chk("R5 combo strobes", {29'd0, s_fr, s_tc, s_lc}, 32'h7);
    chk("R5 strobe one cycle", {29'd0, fifo_reset_p, trig_clr_p, lost_clr_p}, 32'd0);
    xfer(1, addr_of(8'h55, 16'h000C), 16'h0008);
    chk("R5 single strobe", {29'd0, s_fr, s_tc, s_lc}, 32'h2);
    xfer(0, addr_of(8'h55, 16'h000C), 0);
    chk("R5 pulse reads zero", {16'd0, s_rdata}, 32'd0);

    xfer(0, addr_of(8'h55, 16'h0008), 0);
    chk("R6 status clean", {16'd0, s_rdata}, {16'd0, exp_status(1, 1, 0, 0)});
    @(negedge clk); link_lock_in = 1'b0;
    @(negedge clk); link_lock_in = 1'b1;
    xfer(1, addr_of(8'h55, 16'h0008), 16'h0000);
    xfer(0, addr_of(8'h55, 16'h0008), 0);
    chk("R6 R7 link loss sticky", {16'd0, s_rdata}, {16'd0, exp_status(1, 1, 1, 0)});
    xfer(1, addr_of(8'h55, 16'h000C), 16'h0020);
    xfer(0, addr_of(8'h55, 16'h0008), 0);
    chk("R7 cleared", {16'd0, s_rdata}, {16'd0, exp_status(1, 1, 0, 0)});
    @(negedge clk); sm_lock_in = 1'b0;
    xfer(1, addr_of(8'h55, 16'h000C), 16'h0020);
    @(negedge clk); sm_lock_in = 1'b1;
    xfer(0, addr_of(8'h55, 16'h0008), 0);
    chk("R7 loss wins over clear", {16'd0, s_rdata}, {16'd0, exp_status(1, 1, 0, 1)});
    xfer(1, addr_of(8'h55, 16'h000C), 16'h0020);
    xfer(0, addr_of(8'h55, 16'h0008), 0);
    chk("R7 cleared again", {16'd0, s_rdata}, {16'd0, exp_status(1, 1, 0, 0)});

    xfer(0, addr_of(8'h55, 16'h1000), 0);
    chk("R8 fifo data", {16'd0, s_rdata}, 32'h0000A5C3);
    chk("R8 fifo pop", {31'd0, s_rd_en}, 32'd1);
    xfer(1, addr_of(8'h55, 16'h1000), 16'h1234);
    chk("R8 write no pop", {31'd0, s_rd_en}, 32'd0);
    xfer(0, addr_of(8'h55, 16'h2000), 0);
    chk("R9 unmapped ack", {31'd0, s_ack}, 32'd1);
    chk("R9 unmapped zero", {16'd0, s_rdata}, 32'd0);

    for (int i = 0; i < 300; i++) begin
      logic [15:0] d, o;
      logic [7:0] b;
      d = 16'($urandom);
      case ($urandom % 4)
        0: begin
          xfer(1, addr_of(8'h55, 16'h0068), d); m_cfg = d;
          chk("R4 rand outputs", {30'd0, clk_sel_local, strict_lock}, {30'd0, m_cfg[15], m_cfg[7]});
        end
        1: begin
          xfer(0, addr_of(8'h55, 16'h0068), 0);
          chk("R3 rand readback", {16'd0, s_rdata}, {16'd0, m_cfg});
        end
        2: begin
          b = 8'($urandom); if (b == 8'h55) b = 8'hAA;
          xfer(1, addr_of(b, 16'h0068), d);
          chk("R1 rand foreign", {31'd0, s_ack}, 32'd0);
          xfer(0, addr_of(8'h55, 16'h0068), 0);
          chk("R1 rand cfg kept", {16'd0, s_rdata}, {16'd0, m_cfg});
        end
        default: begin
          o = {d[15:2], 2'b00};
          if (o == 16'h0008 || o == 16'h000C || o == 16'h0068 || o == 16'h1000) o = 16'h0100;
          xfer(0, addr_of(8'h55, o), 0);
          chk("R9 rand unmapped", {15'd0, s_ack, s_rdata}, 32'h00010000);
        end
      endcase
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule